// File: doc/BRIEF.md
# Paged SPI Register Access Controller

This block turns single register requests from a host into SPI frames for a peripheral whose registers sit on two pages. The host gives an 8-bit register identifier, a write flag and, for writes, a 10-bit value. The controller remembers which page the peripheral currently has selected. When an access targets the other page, or no page is known yet, it first writes the page-select register.

A write is sent as one 16-bit frame. A read is sent as the same read frame twice, with an idle gap between the two. The 10-bit result is taken from the reply to the second frame. The block includes its own mode-0 SPI master. Each request ends with a one-cycle `done` pulse. `busy` covers the whole sequence, and the block takes no new request while it is high.

Top module: `paged_spi_ctrl`

## Requirements
- R1: In the register identifier, bit 7 is the page and bits 5:0 are the in-page address. Bit 6 has no effect on any frame.
- R2: A write sends one frame equal to (data << 6) | (address << 1). Bit 0 is 0, and the shift makes data bit 0 and address bit 5 OR together into frame bit 6.
- R3: A read sends the frame (address << 1) | 1 twice. Both frames have a zero data field.
- R4: When the request's page differs from the tracked page, the block first sends a write to the page-select register PAGE_REG_ID. The value is 1 for page 0 and 2 for page 1. The tracked page is then updated, so a later access to the same page sends no page-select frame.
- R5: A write whose identifier equals PAGE_REG_ID never causes an automatic page-select frame, and it leaves the tracked page unchanged.
- R6: After reset the tracked page is unknown, so the first access of any other kind is preceded by a page-select frame.
- R7: Between the two frames of a read, chip select stays high for at least READ_GAP system clocks.
- R8: On `done` after a read, `rd_data` equals bits 15:6 of the word received during the second read frame.
- R9: `busy` rises the cycle after a request is accepted. `done` is a one-cycle pulse during which `busy` is already low. A request presented while `busy` is high produces no frame and no `done`.
- R10: The SPI interface runs in mode 0. SCLK idles low. Chip select stays low for exactly 16 SCLK periods per frame. Data goes out MSB first and changes only while SCLK is low. MISO is sampled on the rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | 8 | Register identifier (page in bit 7, address in bits 5:0) |
| req_wdata | input | 10 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 10 | Read result, valid at done after a read |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to peripheral |
| miso | input | 1 | SPI data from peripheral |

## Verification
A wrong tracked page shows up on the bus within the next request: a page-select frame is either missing or extra, so the frame count and the first frame of that request both differ from the model. A fault in the frame shift or bit counter shows up within one frame, as a wrong bit count or wrong word on MOSI. A read sequencing fault shows at the `done` of that request: wrong `rd_data` if the first reply was used, or a short chip-select gap. Requests poked while busy show up a few cycles later as unexpected frames.

// File: rtl/paged_spi_pkg.sv
package paged_spi_pkg;
  localparam int FRAME_W  = 16;
  localparam int DATA_W   = 10;
  localparam int ADDR_W   = 6;
  localparam int ID_W     = 8;
  localparam int DATA_LSB = FRAME_W - DATA_W;
  localparam int PAGE_BIT = ID_W - 1;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_SEL, SQ_SEL_W, SQ_ACC, SQ_ACC_W,
    SQ_GAP, SQ_RD2, SQ_RD2_W, SQ_FIN
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] pack_write(input logic [ADDR_W-1:0] a,
                                                     input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] f;
    f = (FRAME_W'(d) << DATA_LSB) | (FRAME_W'(a) << 1);
    return f;
  endfunction

  function automatic logic [FRAME_W-1:0] pack_read(input logic [ADDR_W-1:0] a);
    return (FRAME_W'(a) << 1) | FRAME_W'(1);
  endfunction
endpackage

// File: rtl/spi_mode0_master.sv
module spi_mode0_master
  import paged_spi_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_frame,
  output logic               frame_done,
  output logic [FRAME_W-1:0] rx_frame,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic               active;
  logic [DIV_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      div_cnt    <= '0;
      bit_cnt    <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_frame   <= '0;
      frame_done <= 1'b0;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      mosi       <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          cs_n    <= 1'b0;
          tx_sh   <= tx_frame;
          mosi    <= tx_frame[FRAME_W-1];
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[FRAME_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == BIT_LAST) begin
            active     <= 1'b0;
            cs_n       <= 1'b1;
            frame_done <= 1'b1;
            rx_frame   <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
            mosi    <= tx_sh[FRAME_W-2];
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_tracker.sv
module page_tracker
  import paged_spi_pkg::*;
#(
  parameter logic [ID_W-1:0] PAGE_REG_ID = 8'h01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ID_W-1:0]    req_id,
  input  logic               req_write,
  input  logic               upd,
  input  logic               upd_page,
  output logic               need_switch,
  output logic [FRAME_W-1:0] sel_frame
);
  logic page_known;
  logic page_q;
  logic is_sel_write;
  logic [DATA_W-1:0] sel_value;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_known <= 1'b0;
      page_q     <= 1'b0;
    end else if (upd) begin
      page_known <= 1'b1;
      page_q     <= upd_page;
    end
  end

  always_comb begin
    is_sel_write = req_write && (req_id == PAGE_REG_ID);
    need_switch  = !is_sel_write && (!page_known || (page_q != req_id[PAGE_BIT]));
    sel_value    = req_id[PAGE_BIT] ? DATA_W'(2) : DATA_W'(1);
    sel_frame    = pack_write(PAGE_REG_ID[ADDR_W-1:0], sel_value);
  end
endmodule

// File: rtl/access_sequencer.sv
module access_sequencer
  import paged_spi_pkg::*;
#(
  parameter int READ_GAP = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ID_W-1:0]    req_id,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               need_switch,
  input  logic [FRAME_W-1:0] sel_frame,
  output logic               page_upd,
  output logic               page_upd_val,
  output logic               eng_start,
  output logic [FRAME_W-1:0] eng_tx,
  input  logic               eng_done,
  input  logic [FRAME_W-1:0] eng_rx,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int GAP_W = $clog2(READ_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(READ_GAP - 1);

  seq_state_t         state;
  logic               wr_q;
  logic [ID_W-1:0]    id_q;
  logic [DATA_W-1:0]  data_q;
  logic [FRAME_W-1:0] sel_q;
  logic [GAP_W-1:0]   gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SQ_IDLE;
      wr_q         <= 1'b0;
      id_q         <= '0;
      data_q       <= '0;
      sel_q        <= '0;
      gap_cnt      <= '0;
      page_upd     <= 1'b0;
      page_upd_val <= 1'b0;
      eng_start    <= 1'b0;
      eng_tx       <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      rd_data      <= '0;
    end else begin
      eng_start <= 1'b0;
      page_upd  <= 1'b0;
      done      <= 1'b0;
      case (state)
        SQ_IDLE: if (req_valid) begin
          busy   <= 1'b1;
          wr_q   <= req_write;
          id_q   <= req_id;
          data_q <= req_wdata;
          sel_q  <= sel_frame;
          state  <= need_switch ? SQ_SEL : SQ_ACC;
        end
        SQ_SEL: begin
          eng_start <= 1'b1;
          eng_tx    <= sel_q;
          state     <= SQ_SEL_W;
        end
        SQ_SEL_W: if (eng_done) begin
          page_upd     <= 1'b1;
          page_upd_val <= id_q[PAGE_BIT];
          state        <= SQ_ACC;
        end
        SQ_ACC: begin
          eng_start <= 1'b1;
          eng_tx    <= wr_q ? pack_write(id_q[ADDR_W-1:0], data_q)
                            : pack_read(id_q[ADDR_W-1:0]);
          state     <= SQ_ACC_W;
        end
        SQ_ACC_W: if (eng_done) begin
          gap_cnt <= '0;
          state   <= wr_q ? SQ_FIN : SQ_GAP;
        end
        SQ_GAP: begin
          if (gap_cnt == GAP_LAST) state <= SQ_RD2;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        SQ_RD2: begin
          eng_start <= 1'b1;
          state     <= SQ_RD2_W;
        end
        SQ_RD2_W: if (eng_done) begin
          rd_data <= eng_rx[FRAME_W-1:DATA_LSB];
          state   <= SQ_FIN;
        end
        SQ_FIN: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/paged_spi_ctrl.sv
module paged_spi_ctrl
  import paged_spi_pkg::*;
#(
  parameter int               CLK_DIV     = 4,
  parameter int               READ_GAP    = 13000,
  parameter logic [ID_W-1:0]  PAGE_REG_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic               need_switch;
  logic [FRAME_W-1:0] sel_frame;
  logic               page_upd;
  logic               page_upd_val;
  logic               eng_start;
  logic [FRAME_W-1:0] eng_tx;
  logic               eng_done;
  logic [FRAME_W-1:0] eng_rx;

  page_tracker #(.PAGE_REG_ID(PAGE_REG_ID)) u_page (
    .clk(clk), .rst(rst), .req_id(req_id), .req_write(req_write),
    .upd(page_upd), .upd_page(page_upd_val),
    .need_switch(need_switch), .sel_frame(sel_frame)
  );

  access_sequencer #(.READ_GAP(READ_GAP)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_id(req_id), .req_wdata(req_wdata), .need_switch(need_switch),
    .sel_frame(sel_frame), .page_upd(page_upd), .page_upd_val(page_upd_val),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  spi_mode0_master #(.CLK_DIV(CLK_DIV)) u_spi (
    .clk(clk), .rst(rst), .start(eng_start), .tx_frame(eng_tx),
    .frame_done(eng_done), .rx_frame(eng_rx),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );
endmodule

// File: rtl/paged_spi_ctrl_checker.sv
module paged_spi_ctrl_checker
  import paged_spi_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);
  localparam int EDGE_W = $clog2(FRAME_W + 1) + 1;
  logic              sclk_d;
  logic [EDGE_W-1:0] edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      edges  <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n) edges <= '0;
      else if (sclk && !sclk_d) edges <= edges + 1'b1;
    end
  end

  assert_frame_len_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (edges == EDGE_W'(FRAME_W)));
  assert_idle_clock_low_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_mosi_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  assert_idle_no_frame_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
endmodule

bind paged_spi_ctrl paged_spi_ctrl_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
  .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/paged_spi_ctrl_test.sv
module paged_spi_ctrl_test;
  localparam int CLK_DIV = 2;
  localparam int READ_GAP = 20;
  localparam logic [7:0] PAGE_ID = 8'h01;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_id = 0;
  logic [9:0] req_wdata = 0;
  logic busy, done, sclk, cs_n, mosi;
  logic miso = 0;
  logic [9:0] rd_data;

  paged_spi_ctrl #(.CLK_DIV(CLK_DIV), .READ_GAP(READ_GAP), .PAGE_REG_ID(PAGE_ID)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_id(req_id), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // SPI peripheral model
  logic [15:0] frames [0:15];
  int fbits [0:15];
  int fall_c [0:15];
  int rise_c [0:15];
  int nfr = 0;
  int frame_idx = 0;
  logic [15:0] cap_sh, resp;
  int cap_bits, bit_i;

  function automatic logic [15:0] slave_word(int k);
    return 16'((k * 40503 + 12345) ^ (k << 7));
  endfunction

  always @(negedge cs_n) begin
    cap_sh = 0; cap_bits = 0;
    resp = slave_word(frame_idx);
    bit_i = 15; miso = resp[15];
    if (nfr < 16) fall_c[nfr] = cyc;
  end
  always @(posedge sclk) if (!cs_n) begin
    cap_sh = {cap_sh[14:0], mosi}; cap_bits++;
  end
  always @(negedge sclk) if (!cs_n) begin
    bit_i--;
    if (bit_i >= 0) miso = resp[bit_i];
  end
  always @(posedge cs_n) if (!rst) begin
    if (nfr < 16) begin
      frames[nfr] = cap_sh; fbits[nfr] = cap_bits; rise_c[nfr] = cyc;
    end
    nfr++; frame_idx++;
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference model
  bit pg_known = 0;
  bit pg = 0;

  function automatic logic [15:0] exp_write(logic [7:0] id, logic [9:0] d);
    return (16'(d) << 6) | (16'(id[5:0]) << 1);
  endfunction

  task automatic do_req(bit wr, logic [7:0] id, logic [9:0] d, bit poke, string tag);
    logic [15:0] ex [0:2];
    string tg [0:2];
    int ne = 0;
    int base;
    bit sw;
    sw = !(wr && id == PAGE_ID) && (!pg_known || pg != id[7]);
    if (sw) begin
      ex[ne] = exp_write(PAGE_ID, id[7] ? 10'd2 : 10'd1); tg[ne] = "R4"; ne++;
    end
    if (wr) begin
      ex[ne] = exp_write(id, d); tg[ne] = tag; ne++;
    end else begin
      ex[ne] = (16'(id[5:0]) << 1) | 16'd1; tg[ne] = tag; ne++;
      ex[ne] = (16'(id[5:0]) << 1) | 16'd1; tg[ne] = tag; ne++;
    end
    @(negedge clk);
    nfr = 0; base = frame_idx;
    req_valid = 1; req_write = wr; req_id = id; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_write = 1; req_id = ~id; req_wdata = ~d;
      @(negedge clk);
      req_valid = 0;
    end
    for (int i = 0; i < 5000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check(done == 1'b1 && busy == 1'b0, "R9 done with busy low", {busy, done}, 2'b01);
    if (!wr)
      check(rd_data == slave_word(base + ne - 1) >> 6, "R8 read data", rd_data,
            slave_word(base + ne - 1) >> 6);
    repeat (10) @(negedge clk);
    check(nfr == ne, poke ? "R9 frame count with poke while busy" : "R4 frame count", nfr, ne);
    for (int i = 0; i < ne && i < nfr; i++) begin
      check(frames[i] == ex[i], tg[i], frames[i], ex[i]);
      check(fbits[i] == 16, "R10 bits per frame", fbits[i], 16);
    end
    if (!wr && nfr == ne)
      check(fall_c[ne-1] - rise_c[ne-2] >= READ_GAP, "R7 read gap",
            fall_c[ne-1] - rise_c[ne-2], READ_GAP);
    if (sw) begin pg_known = 1; pg = id[7]; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R10 R9 reset state",
          {cs_n, sclk, busy, done}, 4'b1000);
    do_req(1, 8'h05, 10'h2A5, 0, "R6 R2 first write");
    do_req(1, 8'h12, 10'h001, 0, "R2 same page write");
    do_req(1, 8'h20, 10'h3FF, 0, "R2 bit6 overlap");
    do_req(0, 8'h83, 10'h000, 0, "R3 read page1");
    do_req(1, PAGE_ID, 10'h155, 0, "R5 page register write");
    do_req(0, 8'hC5, 10'h000, 0, "R1 bit6 ignored read");
    do_req(1, 8'h47, 10'h0F0, 0, "R1 R4 back to page0");
    do_req(0, 8'h3F, 10'h000, 1, "R3 read with poke");
    do_req(1, 8'hBE, 10'h200, 1, "R2 write with poke");
    for (int n = 0; n < 50; n++) begin
      logic [7:0] id;
      bit wr;
      id = 8'($urandom);
      if (($urandom % 8) == 0) id = PAGE_ID;
      wr = 1'($urandom);
      do_req(wr, id, 10'($urandom), ($urandom % 6) == 0, wr ? "R2 random write" : "R3 random read");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule